// File: doc/BRIEF.md
# Reuse Filter Cache Front-End

This block sits in front of a direct-mapped main cache and decides which lines earn a place there. A small fully associative buffer receives every line that memory returns. A line moves into the main cache only when a second request finds it while it is still in the buffer. Lines that are used once stay in the buffer until newer fills push them out in least-recently-filled order, so they never take space in the main cache.

Both structures are looked up in the same cycle. The response comes one cycle after the request and reports whether the request hit, which structure supplied the line, and the line data. The line data for a miss arrives later on the fill port. Memory, write-back and coherence are handled outside the block. Addresses are line addresses. The main cache index is the low `log2(MAIN_SETS)` bits of the address.

Top module: `reuse_filter_cache`

## Requirements
- R1: After reset both structures are empty, `resp_valid` is 0, and the first request to any address misses.
- R2: `resp_valid` is 1 in the cycle after a cycle with `req_valid` high, and 0 in every other cycle.
- R3: A request that misses in both structures returns `resp_hit`=0, `resp_main`=0 and `resp_data`=0, and allocates nothing: a repeated request without a fill misses again.
- R4: A fill writes the line into the filter buffer. A later request to that address hits with the filled data.
- R5: A request that hits in the filter buffer moves the line into the main cache and removes it from the buffer. The next request to that address hits with `resp_main`=1 and the same data.
- R6: A line seen for the first time never enters the main cache. The first hit after a fill reports `resp_main`=0.
- R7: A fill goes into a free buffer entry whenever one exists, so up to FILT_N lines filled in a row all remain present.
- R8: A fill into a full buffer replaces the entry whose fill is oldest. Entries emptied by promotion are reused before any valid entry is replaced.
- R9: When a promotion lands on a main cache index that already holds another line, the old line is dropped. A later request to the old line misses.
- R10: No line is valid in the filter buffer and the main cache at the same time.
- R11: A hit in the main cache leaves the filter buffer contents and their replacement order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Line address to look up |
| fill_valid | input | 1 | Line returned from memory |
| fill_addr | input | ADDR_W | Address of the returned line |
| fill_data | input | DATA_W | Data of the returned line |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_hit | output | 1 | Request found its line |
| resp_main | output | 1 | Line came from the main cache (0 means it came from the filter buffer) |
| resp_data | output | DATA_W | Line data on a hit, zero on a miss |

## Verification
The assertions assume that a fill is only issued for an address that is absent from both structures. This assumption is what makes buffer matches one-hot and keeps the two structures exclusive. They also assume that a fill and a request do not address the same line in the same cycle. The bench keeps a model of both structures and turns any randomly chosen fill to a resident address into a request instead. It also never drives a fill and a request in the same cycle. Its address pool is kept small so that main cache index collisions and buffer evictions happen often.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  // Low part of a line address selects the main cache set
  function automatic logic [31:0] set_of(input logic [31:0] a, input int unsigned iw);
    return a & ((32'd1 << iw) - 32'd1);
  endfunction

  // Remaining upper part is the stored tag
  function automatic logic [31:0] tag_of(input logic [31:0] a, input int unsigned iw);
    return a >> iw;
  endfunction
endpackage

// File: rtl/rfc_filter.sv
module rfc_filter #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              promote,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [IDX_W-1:0]   age_q  [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx, vic_idx;
  logic               free_found;
  logic [ENTRIES-1:0] age_seen;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (addr_q[g] == lk_addr);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_idx = IDX_W'(i);
        lk_data = data_q[i];
      end
    end
  end

  assign lk_hit  = |match;
  assign promote = lk_en && lk_hit;

  // victim: lowest free entry, otherwise the oldest one
  always_comb begin
    free_found = 1'b0;
    vic_idx    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_q[i] && !free_found) begin
        vic_idx    = IDX_W'(i);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age_q[i] == OLDEST) vic_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else begin
      if (promote) valid_q[hit_idx] <= 1'b0;
      if (fill_en) begin
        valid_q[vic_idx] <= 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == vic_idx)          age_q[i] <= '0;
          else if (age_q[i] < age_q[vic_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      addr_q[vic_idx] <= fill_addr;
      data_q[vic_idx] <= fill_data;
    end
  end

  always_comb begin
    age_seen = '0;
    for (int i = 0; i < ENTRIES; i++) age_seen[age_q[i]] = 1'b1;
  end

  // R10
  match_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R7
  free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(&valid_q) && !promote)
      |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

  // R8
  full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && (&valid_q) && !promote) |=> (&valid_q));

  // R8
  lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&age_seen));
endmodule

// File: rtl/rfc_main.sv
module rfc_main #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx = IDX_W'(rfc_pkg::set_of(32'(rd_addr), IDX_W));
  assign rd_tag = TAG_W'(rfc_pkg::tag_of(32'(rd_addr), IDX_W));
  assign wr_idx = IDX_W'(rfc_pkg::set_of(32'(wr_addr), IDX_W));
  assign wr_tag = TAG_W'(rfc_pkg::tag_of(32'(wr_addr), IDX_W));

  assign rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_data = data_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // displaced line is simply overwritten
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  // R5
  promo_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/reuse_filter_cache.sv
module reuse_filter_cache #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int FILT_N    = 4,
  parameter int MAIN_SETS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_main,
  output logic [DATA_W-1:0] resp_data
);
  logic              f_hit, m_hit, promote;
  logic [DATA_W-1:0] f_data, m_data;

  rfc_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(FILT_N)) u_filt (
    .clk(clk), .rst_n(rst_n),
    .lk_en(req_valid), .lk_addr(req_addr),
    .lk_hit(f_hit), .lk_data(f_data), .promote(promote),
    .fill_en(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
  );

  rfc_main #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(MAIN_SETS)) u_main (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(req_addr), .rd_hit(m_hit), .rd_data(m_data),
    .wr_en(promote), .wr_addr(req_addr), .wr_data(f_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_main  <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_hit   <= req_valid && (f_hit || m_hit);
      resp_main  <= req_valid && m_hit;
      resp_data  <= !req_valid ? '0 : f_hit ? f_data : m_hit ? m_data : '0;
    end
  end

  // R10
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(f_hit && m_hit));

  // R2
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R2
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_data == '0 && !resp_main));
endmodule

// File: tb/sim_reuse_filter_cache.sv
module sim_reuse_filter_cache;
  localparam int AW = 12, DW = 32, FN = 4, MS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, fill_valid = 1'b0;
  logic [AW-1:0] req_addr = '0, fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic resp_valid, resp_hit, resp_main;
  logic [DW-1:0] resp_data;

  int errors = 0, checks = 0, stamp = 0;
  bit finished = 1'b0;

  // bench model
  bit            f_ok [FN];
  logic [AW-1:0] f_a  [FN];
  logic [DW-1:0] f_d  [FN];
  int            f_t  [FN];
  bit            m_ok [MS];
  logic [AW-1:0] m_a  [MS];
  logic [DW-1:0] m_d  [MS];

  always #2.5 clk = ~clk;

  reuse_filter_cache #(.ADDR_W(AW), .DATA_W(DW), .FILT_N(FN), .MAIN_SETS(MS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_main(resp_main),
    .resp_data(resp_data)
  );

  function automatic int set_no(input logic [AW-1:0] a);
    return int'(a) % MS;
  endfunction

  function automatic int find_f(input logic [AW-1:0] a);
    for (int i = 0; i < FN; i++) if (f_ok[i] && f_a[i] == a) return i;
    return -1;
  endfunction

  function automatic bit in_main(input logic [AW-1:0] a);
    return m_ok[set_no(a)] && m_a[set_no(a)] == a;
  endfunction

  function automatic int pick_slot();
    int best = 0;
    for (int i = 0; i < FN; i++) if (!f_ok[i]) return i;
    for (int i = 1; i < FN; i++) if (f_t[i] < f_t[best]) best = i;
    return best;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [AW-1:0] a, input string req);
    int fi = find_f(a);
    bit eh = (fi >= 0) || in_main(a);
    bit em = in_main(a);
    logic [DW-1:0] ed = (fi >= 0) ? f_d[fi] : em ? m_d[set_no(a)] : '0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid == 1'b1, {req, " R2 valid"}, resp_valid, 1);
    chk(resp_hit == eh, {req, " hit"}, resp_hit, eh);
    chk(resp_main == em, {req, " main"}, resp_main, em);
    chk(resp_data == ed, {req, " data"}, resp_data, ed);
    if (fi >= 0) begin
      f_ok[fi] = 1'b0;
      m_ok[set_no(a)] = 1'b1; m_a[set_no(a)] = a; m_d[set_no(a)] = f_d[fi];
    end
  endtask

  task automatic do_fill(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int s = pick_slot();
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
    chk(resp_valid == 1'b0, "R2 idle", resp_valid, 0);
    f_ok[s] = 1'b1; f_a[s] = a; f_d[s] = d; f_t[s] = stamp; stamp++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < FN; i++) begin f_ok[i] = 0; f_t[i] = 0; end
    for (int i = 0; i < MS; i++) m_ok[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(resp_valid == 1'b0, "R1 reset valid", resp_valid, 0);

    do_req(12'h010, "R1 first miss");
    do_req(12'h010, "R3 no alloc");
    do_fill(12'h010, 32'hA0A0_0001);
    do_req(12'h010, "R4 R6 filter hit");
    do_req(12'h010, "R5 main hit");

    // R7 four fills all stay
    for (int i = 1; i <= FN; i++) do_fill(12'h100 + 12'(i), 32'hB000_0000 + i);
    for (int i = 1; i <= FN; i++) do_req(12'h100 + 12'(i), "R7 all present");

    // R8 reuse of freed slot, then oldest fill replaced
    for (int i = 1; i <= FN; i++) do_fill(12'h200 + 12'(i * 8), 32'hC000_0000 + i);
    do_req(12'h210, "R8 promote second");
    do_fill(12'h300, 32'hD000_0001);
    do_fill(12'h308, 32'hD000_0002);
    do_req(12'h208, "R8 oldest evicted");
    do_req(12'h218, "R8 survivor");

    // R9 same-set promotions displace
    do_fill(12'h020, 32'hE000_0001); do_req(12'h020, "R9 promote X");
    do_fill(12'h028, 32'hE000_0002); do_req(12'h028, "R9 promote Y");
    do_req(12'h020, "R9 X displaced");
    do_req(12'h028, "R9 Y in main");

    // R11 main hits leave filter order intact
    for (int i = 0; i < FN; i++) do_fill(12'h400 + 12'(i * 8), 32'hF000_0000 + i);
    do_req(12'h028, "R11 main hit");
    do_req(12'h028, "R11 main hit again");
    do_fill(12'h500, 32'hF000_00FF);
    do_req(12'h400, "R11 oldest still evicted");
    do_req(12'h408, "R11 next kept");

    // random mix, R10 exclusivity tracked by model
    for (int n = 0; n < 800; n++) begin
      logic [AW-1:0] a = 12'h600 + 12'($urandom_range(0, 23));
      if ($urandom_range(0, 9) < 4 && find_f(a) < 0 && !in_main(a))
        do_fill(a, $urandom);
      else
        do_req(a, "R10 random");
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule